// File: doc/BRIEF.md
# Seven-Source Interrupt Cause Controller

This block gathers seven level-sensitive event lines into one interrupt request for a parent controller. Each event line latches into its own bit of a cause register. A mask register selects which pending causes may raise the shared request line. Both registers sit on a simple register bus with a write strobe, a byte address and 32-bit data. Reads return data combinationally from the address.

Software finds pending sources by reading the cause register, then writes it back to clear them. The cause register is plain read/write and not write-zero-to-clear. Writing a 1 therefore raises a pending bit by software, and writing a 0 clears it. A read-modify-write sequence can lose an event that arrives between the read and the write, unless the event is still present on the cycle of the write. A live event always wins over a written 0 on the same cycle.

The request line is the OR of every pending and enabled cause. It passes through one register before it leaves the block, so it is a level that stays high as long as any enabled cause stays pending.

Top module: `irq_cause_agg`

## Requirements
- R1: After a synchronous reset, the cause register and the mask register both hold zero, and `irq_out` is low.
- R2: An event line `evt_in[i]` that is high at a rising clock edge sets cause bit i at that edge. A read of the cause register (byte offset 0x50) on the following cycle returns bit i as 1.
- R3: A bus write to offset 0x50 loads each cause bit 0..6 with the written data bit. A written 1 sets the bit even when no event is present.
- R4: A cause bit stays pending until it is cleared by a bus write of 0 to that bit. A written 0 clears the bit when its event line is low.
- R5: When an event line is high on the same edge as a bus write of 0 to its cause bit, the bit ends up 1.
- R6: A bus write to offset 0x54 loads the mask register bits 0..6 from the written data. A mask bit of 1 enables its source, and a read of offset 0x54 returns the stored mask.
- R7: `irq_out` goes high one clock cycle after the registers first hold a cause bit that is both pending and enabled. It stays high while that holds, and it falls one cycle after no enabled cause remains pending.
- R8: A pending cause whose mask bit is 0 never raises `irq_out`.
- R9: Bits 7 to 31 of both registers read as zero, and data written to those bit positions is discarded.
- R10: A write to any address other than 0x50 or 0x54 changes neither register. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 7 | Level-sensitive event lines, one per source |
| irq_out | output | 1 | Registered combined interrupt request to the parent |

## Verification
The bound checker watches several behaviours on every cycle:
- how the cause bits respond to events, to writes and to idle cycles;
- how mask writes load and hold the mask;
- the one-cycle relation between the pending-and-enabled set and `irq_out`;
- that the upper read bits stay zero.

Other behaviours are only visible through the bench's scenarios:
- a read-modify-write in which an event collides with a clearing write;
- the exact cycle on which `irq_out` rises after a software-set cause;
- that writes to an unmapped address leave both registers untouched;
- a reset in the middle of a run.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    localparam int DEF_NUM_SRC = 7;
    localparam int DEF_ADDR_W  = 8;
    localparam int DEF_DATA_W  = 32;
    localparam logic [DEF_ADDR_W-1:0] DEF_CAUSE_OFS = 8'h50;
    localparam logic [DEF_ADDR_W-1:0] DEF_MASK_OFS  = 8'h54;

    // Which register an access targets
    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_CAUSE = 2'd1,
        REG_MASK  = 2'd2
    } reg_id_e;

    // Decoded bus access
    typedef struct packed {
        reg_id_e target;
        logic    wr_cause;
        logic    wr_mask;
    } reg_sel_t;

    function automatic reg_sel_t decode_access(
        input logic                  wr,
        input logic [DEF_ADDR_W-1:0] addr,
        input logic [DEF_ADDR_W-1:0] cause_ofs,
        input logic [DEF_ADDR_W-1:0] mask_ofs
    );
        reg_sel_t s;
        s.target   = REG_NONE;
        if (addr == cause_ofs)
            s.target = REG_CAUSE;
        else if (addr == mask_ofs)
            s.target = REG_MASK;
        s.wr_cause = wr && (s.target == REG_CAUSE);
        s.wr_mask  = wr && (s.target == REG_MASK);
        return s;
    endfunction

endpackage

// File: rtl/irq_cause_decode.sv
module irq_cause_decode
    import irq_cause_pkg::*;
#(
    parameter logic [DEF_ADDR_W-1:0] CAUSE_OFS = DEF_CAUSE_OFS,
    parameter logic [DEF_ADDR_W-1:0] MASK_OFS  = DEF_MASK_OFS
) (
    input  logic                  wr,
    input  logic [DEF_ADDR_W-1:0] addr,
    output reg_sel_t              sel
);

    always_comb begin
        sel = decode_access(wr, addr, CAUSE_OFS, MASK_OFS);
    end

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_cause,
    input  logic               wr_mask,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] evt,
    output logic [NUM_SRC-1:0] cause,
    output logic [NUM_SRC-1:0] mask
);

    // One flop per source; a live event outranks any bus write
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cause_bit
        always_ff @(posedge clk) begin
            if (rst)
                cause[i] <= 1'b0;
            else if (evt[i])
                cause[i] <= 1'b1;
            else if (wr_cause)
                cause[i] <= wdata[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (wr_mask)
            mask <= wdata;
    end

endmodule

// File: rtl/irq_cause_out.sv
module irq_cause_out #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] cause,
    input  logic [NUM_SRC-1:0] mask,
    output logic               irq
);

    logic any_live;

    always_comb begin
        any_live = |(cause & mask);
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= any_live;
    end

endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
    import irq_cause_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int DATA_W  = DEF_DATA_W,
    parameter logic [DEF_ADDR_W-1:0] CAUSE_OFS = DEF_CAUSE_OFS,
    parameter logic [DEF_ADDR_W-1:0] MASK_OFS  = DEF_MASK_OFS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [DEF_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_SRC-1:0]    evt_in,
    output logic                  irq_out
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    reg_sel_t           sel;
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               cause_wr;
    logic               mask_wr;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
    assign cause_wr = sel.wr_cause;
    assign mask_wr  = sel.wr_mask;

    irq_cause_decode #(
        .CAUSE_OFS (CAUSE_OFS),
        .MASK_OFS  (MASK_OFS)
    ) u_decode (
        .wr   (bus_wr),
        .addr (bus_addr),
        .sel  (sel)
    );

    irq_cause_bank #(
        .NUM_SRC (NUM_SRC)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_cause (cause_wr),
        .wr_mask  (mask_wr),
        .wdata    (bus_wdata[NUM_SRC-1:0]),
        .evt      (evt_in),
        .cause    (cause_q),
        .mask     (mask_q)
    );

    irq_cause_out #(
        .NUM_SRC (NUM_SRC)
    ) u_out (
        .clk   (clk),
        .rst   (rst),
        .cause (cause_q),
        .mask  (mask_q),
        .irq   (irq_out)
    );

    // Read mux; bits above the sources stay zero
    always_comb begin
        unique case (sel.target)
            REG_CAUSE: bus_rdata = {{PAD_W{1'b0}}, cause_q};
            REG_MASK:  bus_rdata = {{PAD_W{1'b0}}, mask_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk #(
    parameter int NUM_SRC = 7,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               cause_wr,
    input logic               mask_wr,
    input logic [NUM_SRC-1:0] wdata_lo,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] cause,
    input logic [NUM_SRC-1:0] mask,
    input logic [DATA_W-1:0]  rdata,
    input logic               irq
);

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cause == '0 && mask == '0 && !irq));

    assert_evt_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((cause & $past(evt)) == $past(evt)));

    // Covers R3 and, through the OR with the events, R5
    assert_cause_write_R3: assert property (@(posedge clk) disable iff (rst)
        cause_wr |=> (cause == ($past(wdata_lo) | $past(evt))));

    assert_cause_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!cause_wr && evt == '0) |=> (cause == $past(cause)));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask == $past(wdata_lo)));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask));

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
        ((cause & mask) != '0) |=> irq);

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ((cause & mask) == '0) |=> !irq);

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:NUM_SRC] == '0);

endmodule

bind irq_cause_agg irq_cause_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cause_wr (cause_wr),
    .mask_wr  (mask_wr),
    .wdata_lo (bus_wdata[NUM_SRC-1:0]),
    .evt      (evt_in),
    .cause    (cause_q),
    .mask     (mask_q),
    .rdata    (bus_rdata),
    .irq      (irq_out)
);

// File: tb/test_irq_cause_agg.sv
`timescale 1ns/1ps
module test_irq_cause_agg;

    localparam logic [7:0] A_CAUSE = 8'h50;
    localparam logic [7:0] A_MASK  = 8'h54;
    localparam logic [7:0] A_OTHER = 8'h58;

    // {op[1:0], data[6:0], evt[6:0], exp_cause[6:0], exp_mask[6:0], exp_irq}
    // op: 0 idle, 1 write cause, 2 write mask
    localparam int NVEC = 10;
    localparam logic [30:0] VEC [NVEC] = '{
        {2'd0, 7'h00, 7'h05, 7'h05, 7'h00, 1'b0},  // R2 events latch, masked
        {2'd2, 7'h01, 7'h00, 7'h05, 7'h01, 1'b1},  // R6 enable bit0
        {2'd1, 7'h04, 7'h00, 7'h04, 7'h01, 1'b0},  // R4 clear bit0
        {2'd1, 7'h44, 7'h00, 7'h44, 7'h01, 1'b0},  // R3 software set bit6
        {2'd2, 7'h7F, 7'h00, 7'h44, 7'h7F, 1'b1},  // R6 enable all
        {2'd1, 7'h00, 7'h10, 7'h10, 7'h7F, 1'b1},  // R5 event beats written 0
        {2'd1, 7'h00, 7'h00, 7'h00, 7'h7F, 1'b0},  // R4 clear all
        {2'd0, 7'h00, 7'h7F, 7'h7F, 7'h7F, 1'b1},  // R2 all events
        {2'd2, 7'h00, 7'h00, 7'h7F, 7'h00, 1'b0},  // R8 all masked
        {2'd1, 7'h00, 7'h00, 7'h00, 7'h00, 1'b0}   // R4 final clear
    };
    localparam string VTAG [NVEC] = '{"R2", "R6", "R4", "R3", "R6",
                                      "R5", "R4", "R2", "R8", "R4"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_in = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_cause_agg i_irq_cause_agg (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt_in),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // One bus cycle: inputs held across exactly one rising edge
    task automatic cycle(input logic wr, input logic [7:0] a,
                         input logic [31:0] d, input logic [6:0] e);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt_in = e;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0; bus_wdata = '0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CAUSE, r); check("R1 cause", r, 32'h0);
        rd(A_MASK, r);  check("R1 mask", r, 32'h0);
        check("R1 irq", {31'h0, irq_out}, 32'h0);

        for (int k = 0; k < NVEC; k++) begin
            logic [30:0] v;
            v = VEC[k];
            if (v[30:29] == 2'd1)
                cycle(1'b1, A_CAUSE, {25'h0, v[28:22]}, v[21:15]);
            else if (v[30:29] == 2'd2)
                cycle(1'b1, A_MASK, {25'h0, v[28:22]}, v[21:15]);
            else
                cycle(1'b0, A_OTHER, 32'h0, v[21:15]);
            settle();
            rd(A_CAUSE, r); check({VTAG[k], " cause"}, r, {25'h0, v[14:8]});
            rd(A_MASK, r);  check({VTAG[k], " mask"}, r, {25'h0, v[7:1]});
            check({VTAG[k], " irq"}, {31'h0, irq_out}, {31'h0, v[0]});
        end

        // R7 exact latency after a software-set cause
        cycle(1'b1, A_MASK, 32'h1, 7'h0);
        settle();
        cycle(1'b1, A_CAUSE, 32'h1, 7'h0);
        rd(A_CAUSE, r); check("R7 cause visible", r, 32'h1);
        check("R7 irq not yet", {31'h0, irq_out}, 32'h0);
        settle();
        check("R7 irq one cycle later", {31'h0, irq_out}, 32'h1);
        settle();
        check("R7 irq held", {31'h0, irq_out}, 32'h1);

        // R9 upper bits discarded and read as zero
        cycle(1'b1, A_CAUSE, 32'hFFFF_FF81, 7'h0);
        rd(A_CAUSE, r); check("R9 cause upper", r, 32'h1);
        cycle(1'b1, A_MASK, 32'hFFFF_FF80, 7'h0);
        rd(A_MASK, r); check("R9 mask upper", r, 32'h0);
        settle();
        check("R8 irq after mask clear", {31'h0, irq_out}, 32'h0);

        // R10 unmapped write ignored, unmapped read zero
        cycle(1'b1, A_OTHER, 32'hFFFF_FFFF, 7'h0);
        rd(A_CAUSE, r); check("R10 cause untouched", r, 32'h1);
        rd(A_MASK, r);  check("R10 mask untouched", r, 32'h0);
        rd(A_OTHER, r); check("R10 unmapped read", r, 32'h0);
        settle();
        check("R10 irq stays low", {31'h0, irq_out}, 32'h0);

        // R1 reset in mid-run
        cycle(1'b1, A_MASK, 32'h7F, 7'h0);
        cycle(1'b0, A_OTHER, 32'h0, 7'h22);
        settle();
        check("R7 irq before reset", {31'h0, irq_out}, 32'h1);
        rst = 1'b1;
        settle();
        rst = 1'b0;
        rd(A_CAUSE, r); check("R1 cause after reset", r, 32'h0);
        rd(A_MASK, r);  check("R1 mask after reset", r, 32'h0);
        check("R1 irq after reset", {31'h0, irq_out}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule